// File: doc/BRIEF.md
# Fast-Charge Mode Negotiation Controller

This block sits on the port side of a USB charger. It watches the D+ and D- data lines and decides which output voltage the power stage should regulate to. The analog front end reduces each data line to one of three coarse levels: ground (below 0.325 V), about 0.6 V, and about 3.3 V. The block filters each level for a set number of clocks. It then runs the port through several phases in order:

- a battery-charging phase with the two data lines shorted together;
- detection of a device that can negotiate a higher voltage;
- completion of the handshake, which enables a pull-down on D-;
- decoding of the voltage request.

The result is a set-point code in units of one voltage step (0.2 V by default). The code feeds the external feedback driver.

Two request styles are supported. A fixed request selects 5 V, 9 V, 12 V or 20 V. The 20 V request is honoured only when the class input selects the wide range. Continuous mode moves the set point up or down by one step for each qualified pulse on a data line. The set point never goes below 3.6 V and never above the ceiling for the selected class. When the set point drops while the block is outside continuous mode, a one-cycle flag is raised so that downstream overvoltage logic can blank its comparator. Unplugging the device (D+ falls to ground) returns everything to the default state.

Top module: `fcneg_ctrl`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `short_en`=1, `pulldn_en`=0, `vset`=25 (5 V) and `vset_dn_pulse`=0.
- R2: Each data-line input is filtered. A new level must be held on DEB_CYC+1 consecutive rising edges before it counts, so a shorter change has no effect. An accepted change reaches the outputs on the (DEB_CYC+2)-th rising edge after it is applied.
- R3: With the lines shorted, both lines holding 0.6 V (code 2'b01) for DET_CYC filtered cycles opens the short (`short_en`=0). If D+ reaches 3.3 V (code 2'b10) in this phase, the port is treated as legacy: the short stays on and `vset` stays 25 until unplug. Whenever `short_en`=1, `vset` is 25.
- R4: Once the short is open, D+ at 0.6 V with D- at ground (code 2'b00) completes the handshake and sets `pulldn_en`=1. `pulldn_en` and `short_en` are never both 1.
- R5: After the handshake, outside continuous mode, the (D+, D-) levels select the set point. (0.6, 0.6) gives 60 (12 V), (3.3, 0.6) gives 45 (9 V), (3.3, 3.3) gives 100 (20 V) with `class_b`=1, and (0.6, ground) gives 25. Input code 2'b11 is treated as ground.
- R6: (0.6, 3.3) enters continuous mode and leaves `vset` unchanged. In that mode, a D+ excursion to 3.3 V that returns to (0.6, 3.3) adds one to `vset`. A D- excursion to 0.6 V that returns subtracts one.
- R7: In continuous mode `vset` never goes below 18 (3.6 V) and never above 60 (`class_b`=0) or 100 (`class_b`=1). A step that would cross a limit is ignored.
- R8: With `class_b`=0, the (3.3, 3.3) request is ignored and `vset` keeps its value.
- R9: D+ at ground after the handshake returns the port to default: `short_en`=1, `pulldn_en`=0, `vset`=25, and continuous mode is left.
- R10: `vset_dn_pulse` is high for exactly one cycle, on the cycle `vset` decreases, when the new value is not a continuous-mode step. It never pulses for a continuous-mode decrement.
- R11: In continuous mode, (3.3, 0.6) leaves the mode with `vset`=45, and (0.6, ground) leaves it with `vset`=25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| dp_lvl | input | 2 | D+ level code: 00 ground, 01 about 0.6 V, 10 about 3.3 V |
| dm_lvl | input | 2 | D- level code, same encoding |
| class_b | input | 1 | 1 selects the 20 V ceiling, 0 the 12 V ceiling; change only in reset |
| short_en | output | 1 | Enables the switch that shorts D+ to D- |
| pulldn_en | output | 1 | Enables the D- pull-down switch |
| vset | output | VSET_W | Voltage set point in steps of STEP_MV millivolts |
| vset_dn_pulse | output | 1 | One-cycle flag for a set-point drop outside continuous mode |

## Verification
The input filter is followed by one registered decision stage. A level change driven between edges therefore reaches `vset`, `short_en`, `pulldn_en` and the flag on the (DEB_CYC+2)-th rising edge, and device detection adds DET_CYC more edges. The latency and flag checks drive inputs on a falling edge. They then sample on the falling edge just before the due edge, expecting the old value, and on the falling edges just after it, expecting the new value and the one-cycle flag. All other checks wait a settle interval that exceeds the due time by several cycles before sampling.

// File: rtl/fcneg_pkg.sv
package fcneg_pkg;

   // Coarse data-line level reported by the analog comparators.
   typedef enum logic [1:0] {
      LVL_GND = 2'b00,
      LVL_MID = 2'b01,
      LVL_HI  = 2'b10
   } lvl_e;

   // Link phases of the port.
   typedef enum logic [1:0] {
      LNK_SHORT  = 2'b00,
      LNK_OPEN   = 2'b01,
      LNK_READY  = 2'b10,
      LNK_LEGACY = 2'b11
   } link_e;

   // Code 2'b11 has no meaning on the comparator bus; treat it as ground.
   function automatic lvl_e lvl_norm(input logic [1:0] raw);
      lvl_e r;
      if (raw == 2'b11) r = LVL_GND;
      else              r = lvl_e'(raw);
      return r;
   endfunction

endpackage

// File: rtl/fcneg_lvl_filter.sv
module fcneg_lvl_filter
   import fcneg_pkg::*;
#(
   parameter int DEB_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] raw_i,
   output lvl_e       lvl_o
);

   if (DEB_CYC < 0) begin : g_bad_deb
      $error("fcneg_lvl_filter: DEB_CYC must not be negative");
   end

   lvl_e in_n;
   assign in_n = lvl_norm(raw_i);

   if (DEB_CYC == 0) begin : g_pass
      // No filtering: register the normalized level once.
      lvl_e stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stab_q <= LVL_GND;
         else        stab_q <= in_n;
      end
      assign lvl_o = stab_q;
   end else begin : g_deb
      localparam int CNT_W = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

      lvl_e             cand_q;
      lvl_e             stab_q;
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cand_q <= LVL_GND;
            stab_q <= LVL_GND;
            cnt_q  <= '0;
         end else if (in_n != cand_q) begin
            // Any change restarts the qualification window.
            cand_q <= in_n;
            cnt_q  <= '0;
         end else if (cnt_q != CNT_LAST) begin
            cnt_q  <= cnt_q + 1'b1;
         end else begin
            stab_q <= cand_q;
         end
      end
      assign lvl_o = stab_q;
   end

endmodule

// File: rtl/fcneg_link_fsm.sv
module fcneg_link_fsm
   import fcneg_pkg::*;
#(
   parameter int DET_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  lvl_e dp_i,
   input  lvl_e dm_i,
   output logic short_en_o,
   output logic pulldn_en_o,
   output logic ready_o
);

   if (DET_CYC < 1) begin : g_bad_det
      $error("fcneg_link_fsm: DET_CYC must be at least 1");
   end

   localparam int DW = (DET_CYC < 2) ? 1 : $clog2(DET_CYC);
   localparam logic [DW-1:0] DET_LAST = DW'(DET_CYC - 1);

   link_e          st_q,  st_n;
   logic [DW-1:0]  det_q, det_n;
   logic           unplug;
   logic           both_mid;

   assign unplug   = (dp_i == LVL_GND);
   assign both_mid = (dp_i == LVL_MID) && (dm_i == LVL_MID);

   always_comb begin
      st_n  = st_q;
      det_n = '0;
      unique case (st_q)
         LNK_SHORT: begin
            if (dp_i == LVL_HI) begin
               st_n = LNK_LEGACY;
            end else if (both_mid) begin
               if (det_q == DET_LAST) st_n = LNK_OPEN;
               else                   det_n = det_q + 1'b1;
            end
         end
         LNK_OPEN: begin
            if (unplug)                                      st_n = LNK_SHORT;
            else if (dp_i == LVL_MID && dm_i == LVL_GND)     st_n = LNK_READY;
         end
         LNK_READY: begin
            if (unplug) st_n = LNK_SHORT;
         end
         LNK_LEGACY: begin
            if (unplug) st_n = LNK_SHORT;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LNK_SHORT;
         det_q <= '0;
      end else begin
         st_q  <= st_n;
         det_q <= det_n;
      end
   end

   assign short_en_o  = (st_q == LNK_SHORT) || (st_q == LNK_LEGACY);
   assign pulldn_en_o = (st_q == LNK_READY);
   assign ready_o     = (st_q == LNK_READY);

endmodule

// File: rtl/fcneg_setpoint.sv
module fcneg_setpoint
   import fcneg_pkg::*;
#(
   parameter int VSET_W = 7,
   parameter int C_DEF  = 25,
   parameter int C_MIN  = 18,
   parameter int C_9    = 45,
   parameter int C_12   = 60,
   parameter int C_20   = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lvl_e              dp_i,
   input  lvl_e              dm_i,
   input  logic              class_b_i,
   input  logic              ready_i,
   output logic [VSET_W-1:0] vset_o,
   output logic              cont_o,
   output logic              dn_pulse_o
);

   localparam logic [VSET_W-1:0] V_DEF = VSET_W'(C_DEF);
   localparam logic [VSET_W-1:0] V_MIN = VSET_W'(C_MIN);
   localparam logic [VSET_W-1:0] V_9   = VSET_W'(C_9);
   localparam logic [VSET_W-1:0] V_12  = VSET_W'(C_12);
   localparam logic [VSET_W-1:0] V_20  = VSET_W'(C_20);

   logic [VSET_W-1:0] vset_q, vset_n;
   logic              cont_q, cont_n;
   logic              dn_q;
   lvl_e              pdp_q, pdm_q;
   logic [VSET_W-1:0] v_max;

   logic rq_mm, rq_hm, rq_mh, rq_hh, rq_mg;
   logic was_hh, was_mm;

   assign v_max  = class_b_i ? V_20 : V_12;
   assign rq_mm  = (dp_i == LVL_MID) && (dm_i == LVL_MID);
   assign rq_hm  = (dp_i == LVL_HI)  && (dm_i == LVL_MID);
   assign rq_mh  = (dp_i == LVL_MID) && (dm_i == LVL_HI);
   assign rq_hh  = (dp_i == LVL_HI)  && (dm_i == LVL_HI);
   assign rq_mg  = (dp_i == LVL_MID) && (dm_i == LVL_GND);
   assign was_hh = (pdp_q == LVL_HI)  && (pdm_q == LVL_HI);
   assign was_mm = (pdp_q == LVL_MID) && (pdm_q == LVL_MID);

   always_comb begin
      vset_n = vset_q;
      cont_n = cont_q;
      if (!ready_i || dp_i == LVL_GND) begin
         vset_n = V_DEF;
         cont_n = 1'b0;
      end else if (cont_q) begin
         if (rq_mh) begin
            // A pulse ends when the pair returns to the continuous-mode idle.
            if (was_hh && vset_q < v_max)      vset_n = vset_q + 1'b1;
            else if (was_mm && vset_q > V_MIN) vset_n = vset_q - 1'b1;
         end else if (rq_hm) begin
            vset_n = V_9;
            cont_n = 1'b0;
         end else if (rq_mg) begin
            vset_n = V_DEF;
            cont_n = 1'b0;
         end
      end else begin
         if (rq_mm)                  vset_n = V_12;
         else if (rq_hm)             vset_n = V_9;
         else if (rq_hh && class_b_i) vset_n = V_20;
         else if (rq_mg)             vset_n = V_DEF;
         else if (rq_mh)             cont_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vset_q <= V_DEF;
         cont_q <= 1'b0;
         dn_q   <= 1'b0;
         pdp_q  <= LVL_GND;
         pdm_q  <= LVL_GND;
      end else begin
         vset_q <= vset_n;
         cont_q <= cont_n;
         dn_q   <= (vset_n < vset_q) && !cont_n;
         pdp_q  <= dp_i;
         pdm_q  <= dm_i;
      end
   end

   assign vset_o     = vset_q;
   assign cont_o     = cont_q;
   assign dn_pulse_o = dn_q;

endmodule

// File: rtl/fcneg_ctrl.sv
module fcneg_ctrl
   import fcneg_pkg::*;
#(
   parameter int DEB_CYC = 4,
   parameter int DET_CYC = 64,
   parameter int VSET_W  = 7,
   parameter int STEP_MV = 200,
   parameter int DEF_MV  = 5000,
   parameter int MIN_MV  = 3600,
   parameter int V9_MV   = 9000,
   parameter int V12_MV  = 12000,
   parameter int V20_MV  = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        dp_lvl,
   input  logic [1:0]        dm_lvl,
   input  logic              class_b,
   output logic              short_en,
   output logic              pulldn_en,
   output logic [VSET_W-1:0] vset,
   output logic              vset_dn_pulse
);

   localparam int C_DEF = DEF_MV / STEP_MV;
   localparam int C_MIN = MIN_MV / STEP_MV;
   localparam int C_9   = V9_MV  / STEP_MV;
   localparam int C_12  = V12_MV / STEP_MV;
   localparam int C_20  = V20_MV / STEP_MV;
   localparam int NLINE = 2;

   if (STEP_MV < 1) begin : g_bad_step
      $error("fcneg_ctrl: STEP_MV must be positive");
   end
   if ((DEF_MV % STEP_MV) != 0 || (MIN_MV % STEP_MV) != 0 ||
       (V9_MV % STEP_MV) != 0 || (V12_MV % STEP_MV) != 0 ||
       (V20_MV % STEP_MV) != 0) begin : g_bad_grid
      $error("fcneg_ctrl: every voltage must be a whole number of steps");
   end
   if (C_20 >= (1 << VSET_W)) begin : g_bad_width
      $error("fcneg_ctrl: VSET_W too narrow for the highest set point");
   end
   if (!(C_MIN <= C_DEF && C_DEF <= C_9 && C_9 <= C_12 && C_12 <= C_20)) begin : g_bad_order
      $error("fcneg_ctrl: set points must be ordered");
   end

   logic [1:0] raw [NLINE];
   lvl_e       filt [NLINE];
   lvl_e       filt_dp, filt_dm;
   logic       ready_w;
   logic       cont_w;

   assign raw[0] = dp_lvl;
   assign raw[1] = dm_lvl;

   for (genvar i = 0; i < NLINE; i++) begin : g_line
      fcneg_lvl_filter #(.DEB_CYC(DEB_CYC)) i_flt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw[i]),
         .lvl_o (filt[i])
      );
   end

   assign filt_dp = filt[0];
   assign filt_dm = filt[1];

   fcneg_link_fsm #(.DET_CYC(DET_CYC)) i_link (
      .clk         (clk),
      .rst_n       (rst_n),
      .dp_i        (filt_dp),
      .dm_i        (filt_dm),
      .short_en_o  (short_en),
      .pulldn_en_o (pulldn_en),
      .ready_o     (ready_w)
   );

   fcneg_setpoint #(
      .VSET_W (VSET_W),
      .C_DEF  (C_DEF),
      .C_MIN  (C_MIN),
      .C_9    (C_9),
      .C_12   (C_12),
      .C_20   (C_20)
   ) i_sp (
      .clk        (clk),
      .rst_n      (rst_n),
      .dp_i       (filt_dp),
      .dm_i       (filt_dm),
      .class_b_i  (class_b),
      .ready_i    (ready_w),
      .vset_o     (vset),
      .cont_o     (cont_w),
      .dn_pulse_o (vset_dn_pulse)
   );

endmodule

// File: rtl/fcneg_chk.sv
module fcneg_chk #(
   parameter int VSET_W = 7,
   parameter int C_DEF  = 25,
   parameter int C_MIN  = 18,
   parameter int C_12   = 60,
   parameter int C_20   = 100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              class_b,
   input logic              short_en,
   input logic              pulldn_en,
   input logic [VSET_W-1:0] vset,
   input logic              vset_dn_pulse,
   input logic [1:0]        dp_f,
   input logic              cont
);

   AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(short_en && pulldn_en));                                          // R4

   AST_SHORT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      short_en |-> (vset == VSET_W'(C_DEF)));                             // R3

   AST_VSET_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      vset >= VSET_W'(C_MIN));                                            // R7

   AST_VSET_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      vset <= VSET_W'(C_20));                                             // R7

   AST_NARROW_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      !class_b |-> (vset <= VSET_W'(C_12)));                              // R8

   AST_UNPLUG_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (pulldn_en && dp_f == 2'b00) |=>
         (short_en && !pulldn_en && vset == VSET_W'(C_DEF)));             // R9

   AST_CONT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && $past(cont) && vset != $past(vset)) |->
         ((vset - $past(vset)) == VSET_W'(1) ||
          ($past(vset) - vset) == VSET_W'(1)));                           // R6

   AST_FLAG_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      vset_dn_pulse |-> (vset < $past(vset) && !cont));                   // R10

   AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      vset_dn_pulse |=> !vset_dn_pulse);                                  // R10

endmodule

bind fcneg_ctrl fcneg_chk #(
   .VSET_W (VSET_W),
   .C_DEF  (C_DEF),
   .C_MIN  (C_MIN),
   .C_12   (C_12),
   .C_20   (C_20)
) i_fcneg_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .class_b       (class_b),
   .short_en      (short_en),
   .pulldn_en     (pulldn_en),
   .vset          (vset),
   .vset_dn_pulse (vset_dn_pulse),
   .dp_f          (filt_dp),
   .cont          (cont_w)
);

// File: tb/test_fcneg_ctrl.sv
module test_fcneg_ctrl;

   localparam int DEB = 4;
   localparam int DET = 64;
   localparam int VW  = 7;
   localparam logic [1:0] GND = 2'b00;
   localparam logic [1:0] MID = 2'b01;
   localparam logic [1:0] HI  = 2'b10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    dp = GND;
   logic [1:0]    dm = GND;
   logic          class_b = 1'b1;
   logic          short_en, pulldn_en, dn_pulse;
   logic [VW-1:0] vset;

   int checks = 0;
   int errors = 0;
   int flag_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fcneg_ctrl #(.DEB_CYC(DEB), .DET_CYC(DET), .VSET_W(VW)) i_fcneg_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .dp_lvl        (dp),
      .dm_lvl        (dm),
      .class_b       (class_b),
      .short_en      (short_en),
      .pulldn_en     (pulldn_en),
      .vset          (vset),
      .vset_dn_pulse (dn_pulse)
   );

   always @(negedge clk) if (rst_n && dn_pulse) flag_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic do_reset(input logic cls);
      @(negedge clk);
      rst_n = 1'b0; class_b = cls; dp = GND; dm = GND;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (DEB + 6) @(negedge clk);
   endtask

   task automatic drive(input logic [1:0] p, input logic [1:0] m);
      @(negedge clk);
      dp = p; dm = m;
      settle();
   endtask

   task automatic attach();
      @(negedge clk);
      dp = MID; dm = MID;
      repeat (DEB + 10) @(negedge clk);
      chk("R3 short held during detection", short_en, 1);
      repeat (DET) @(negedge clk);
      chk("R3 short opened after detection", short_en, 0);
      chk("R4 pull-down off before handshake end", pulldn_en, 0);
      drive(MID, GND);
      chk("R4 pull-down on after handshake", pulldn_en, 1);
      chk("R4 short stays open", short_en, 0);
      chk("R5 default after handshake", vset, 25);
   endtask

   task automatic pulse_up();
      drive(HI, HI);
      drive(MID, HI);
   endtask

   task automatic pulse_dn();
      drive(MID, MID);
      drive(MID, HI);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; class_b = 1'b1; dp = GND; dm = GND;
      repeat (2) @(negedge clk);
      chk("R1 short in reset", short_en, 1);
      chk("R1 vset in reset", vset, 25);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 short after reset", short_en, 1);
      chk("R1 pull-down after reset", pulldn_en, 0);
      chk("R1 vset after reset", vset, 25);
      chk("R1 flag after reset", dn_pulse, 0);
   endtask

   task automatic t_legacy();
      do_reset(1'b1);
      drive(HI, HI);
      chk("R3 legacy short stays on", short_en, 1);
      @(negedge clk);
      dp = MID; dm = MID;
      repeat (DET + DEB + 10) @(negedge clk);
      chk("R3 legacy ignores detection", short_en, 1);
      chk("R3 legacy no pull-down", pulldn_en, 0);
      drive(HI, MID);
      chk("R3 legacy stays 5 V", vset, 25);
      drive(GND, GND);
      attach();
   endtask

   task automatic t_fixed();
      do_reset(1'b1);
      attach();
      @(negedge clk);
      dp = HI; dm = MID;
      repeat (DEB + 1) @(negedge clk);
      chk("R2 vset not yet changed", vset, 25);
      @(negedge clk);
      chk("R2 R5 9 V on due edge", vset, 45);
      chk("R10 no flag on rise", dn_pulse, 0);
      drive(MID, MID);
      chk("R5 12 V request", vset, 60);
      drive(HI, HI);
      chk("R5 20 V request wide class", vset, 100);
      flag_cnt = 0;
      @(negedge clk);
      dp = HI; dm = MID;
      repeat (DEB + 1) @(negedge clk);
      chk("R10 flag low before drop", dn_pulse, 0);
      @(negedge clk);
      chk("R10 drop to 9 V", vset, 45);
      chk("R10 flag on drop", dn_pulse, 1);
      @(negedge clk);
      chk("R10 flag one cycle", dn_pulse, 0);
      drive(MID, GND);
      chk("R5 back to 5 V", vset, 25);
      chk("R10 flag count", flag_cnt, 2);
      // Short glitch on D+ must be rejected.
      @(negedge clk);
      dp = HI;
      repeat (DEB - 1) @(negedge clk);
      dp = MID;
      settle();
      chk("R2 glitch rejected", vset, 25);
   endtask

   task automatic t_narrow();
      do_reset(1'b0);
      attach();
      drive(HI, HI);
      chk("R8 20 V ignored at 5 V", vset, 25);
      drive(MID, MID);
      chk("R5 12 V narrow class", vset, 60);
      drive(HI, HI);
      chk("R8 20 V ignored at 12 V", vset, 60);
      drive(MID, HI);
      pulse_up();
      pulse_up();
      chk("R7 narrow ceiling", vset, 60);
      pulse_dn();
      chk("R6 step down from ceiling", vset, 59);
   endtask

   task automatic t_cont();
      do_reset(1'b1);
      attach();
      drive(MID, HI);
      chk("R6 entry keeps value", vset, 25);
      flag_cnt = 0;
      for (int k = 0; k < 3; k++) pulse_up();
      chk("R6 three increments", vset, 28);
      pulse_dn();
      chk("R6 one decrement", vset, 27);
      for (int k = 0; k < 10; k++) pulse_dn();
      chk("R7 floor at 3.6 V", vset, 18);
      chk("R10 no flag in continuous mode", flag_cnt, 0);
      drive(HI, MID);
      chk("R11 exit to 9 V", vset, 45);
      drive(MID, MID);
      drive(MID, HI);
      for (int k = 0; k < 45; k++) pulse_up();
      chk("R7 wide ceiling", vset, 100);
      flag_cnt = 0;
      drive(MID, GND);
      chk("R11 exit to 5 V", vset, 25);
      chk("R10 flag on exit drop", flag_cnt, 1);
      drive(MID, HI);
      pulse_up();
      pulse_up();
      chk("R6 re-entry increments", vset, 27);
      drive(GND, GND);
      chk("R9 unplug short on", short_en, 1);
      chk("R9 unplug pull-down off", pulldn_en, 0);
      chk("R9 unplug 5 V", vset, 25);
      attach();
      drive(MID, MID);
      chk("R9 fixed mode after re-attach", vset, 60);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
      end
   end

   initial begin
      t_reset();
      t_legacy();
      t_fixed();
      t_narrow();
      t_cont();
      done = 1'b1;
      report();
   end

endmodule